// File: doc/BRIEF.md
# Masked GPIO Port Register File

This block is the register file and pad-drive logic for one general-purpose I/O port of up to `NUM_PINS` pins. Software reaches it over a simple single-cycle register bus. Through that bus it sets each pin's drive mode, writes output data and reads back the pad levels.

A write-protect mask guards the output-data register. Bits whose mask bit is set keep their value when the data register is written. To change one pin without a read-modify-write, software loads the mask with ones everywhere except that pin, then writes the data register.

Each pin has four drive modes: input, push-pull, open-drain and quasi-bidirectional. The per-pin drive, enable and weak pull-up outputs are registered. Pad inputs pass through a two-flop synchronizer and can be cut off per pin, so that the pin reads 0.

Top module: `gpio_port_regs`

## Requirements
- R1: After a synchronous reset, all of the following hold:
  - every mode field is input (0);
  - the data register reads all ones;
  - the mask and input-disable registers read 0;
  - the output, output-enable and pull-up outputs are 0.
- R2: A write to the data register (word address 1) changes only the bits whose mask bit (word address 2) is 0. Bits with mask 1 keep their old value.
- R3: With the mask loaded with all ones except bit k, a data write changes only pin k.
- R4: Mode 0 (input, field bits [2i+1:2i] of word address 0) gives output enable 0, pull-up 0 and output 0.
- R5: Mode 1 (push-pull) gives output enable 1, and the pad output equals the data bit.
- R6: Mode 2 (open-drain) gives output 0, output enable equal to the inverted data bit, and pull-up 0.
- R7: Mode 3 (quasi-bidirectional) has two cases:
  - data bit 0: drives the pad low (enable 1, output 0);
  - data bit 1: releases the pad (enable 0) with pull-up 1.
- R8: The pin-state register (word address 4) returns each pad level after two synchronizer flops. A read accepted in the clock after a pad change returns the old level, and a read two clocks later returns the new one.
- R9: A pin whose bit is 1 in the input-disable register (word address 3) reads as 0 in the pin-state register.
- R10: Writes to the pin-state register have no effect on any register.
- R11: Read data appears on `bus_rdata` one clock after a read is accepted. It holds its value while no read is accepted.
- R12: Drive outputs follow a register write one clock after the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pad_in | input | NUM_PINS | Raw pad input levels |
| pad_out | output | NUM_PINS | Pad drive value |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pu | output | NUM_PINS | Weak pull-up enable |

## Verification
A corrupted data or mask bit shows on `pad_out`/`pad_oe` one clock after the faulty write. It also shows on the next read of the data register, so masked writes are checked both ways. A wrong mode decode shows at the pad outputs within one clock of the mode write. Each mode is therefore driven with a data pattern that has both 0s and 1s. A synchronizer with the wrong depth or a broken input-disable gate only shows through pin-state reads. These reads are timed exactly one and two clocks after a pad change, so a latency that is off by one is caught.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_INPUT = 2'd0,
    PM_PUSH  = 2'd1,
    PM_DRAIN = 2'd2,
    PM_QUASI = 2'd3
  } pin_mode_e;

  localparam int unsigned REG_MODE  = 0;
  localparam int unsigned REG_DOUT  = 1;
  localparam int unsigned REG_MASK  = 2;
  localparam int unsigned REG_INDIS = 3;
  localparam int unsigned REG_PIN   = 4;

endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [NUM_PINS-1:0]   pin_state,
  output logic [2*NUM_PINS-1:0] mode_q,
  output logic [NUM_PINS-1:0]   dout_q,
  output logic [NUM_PINS-1:0]   mask_q,
  output logic [NUM_PINS-1:0]   indis_q,
  output logic [DATA_W-1:0]     rdata
);
  import gpio_port_pkg::*;

  localparam int unsigned MODE_W = 2 * NUM_PINS;

  logic              wr_en;
  logic              rd_en;
  logic [DATA_W-1:0] rd_next;

  assign wr_en = sel && wr;
  assign rd_en = sel && !wr;

  // Register writes; the data register honours the protect mask
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      dout_q  <= '1;
      mask_q  <= '0;
      indis_q <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_W'(REG_MODE):  mode_q  <= wdata[MODE_W-1:0];
        ADDR_W'(REG_DOUT):  dout_q  <= (dout_q & mask_q) | (wdata[NUM_PINS-1:0] & ~mask_q);
        ADDR_W'(REG_MASK):  mask_q  <= wdata[NUM_PINS-1:0];
        ADDR_W'(REG_INDIS): indis_q <= wdata[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(REG_MODE):  rd_next[MODE_W-1:0]   = mode_q;
      ADDR_W'(REG_DOUT):  rd_next[NUM_PINS-1:0] = dout_q;
      ADDR_W'(REG_MASK):  rd_next[NUM_PINS-1:0] = mask_q;
      ADDR_W'(REG_INDIS): rd_next[NUM_PINS-1:0] = indis_q;
      ADDR_W'(REG_PIN):   rd_next[NUM_PINS-1:0] = pin_state;
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive (
  input  logic                    clk,
  input  logic                    rst,
  input  gpio_port_pkg::pin_mode_e mode,
  input  logic                    dbit,
  output logic                    out_q,
  output logic                    oe_q,
  output logic                    pu_q
);
  import gpio_port_pkg::*;

  logic out_n, oe_n, pu_n;

  always_comb begin
    out_n = 1'b0;
    oe_n  = 1'b0;
    pu_n  = 1'b0;
    case (mode)
      PM_PUSH: begin
        oe_n  = 1'b1;
        out_n = dbit;
      end
      PM_DRAIN: oe_n = ~dbit;
      PM_QUASI: begin
        oe_n = ~dbit;
        pu_n = dbit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
      pu_q  <= 1'b0;
    end else begin
      out_q <= out_n;
      oe_q  <= oe_n;
      pu_q  <= pu_n;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu
);
  import gpio_port_pkg::*;

  localparam int unsigned SYNC_STAGES = 2;

  logic [2*NUM_PINS-1:0] mode_q;
  logic [NUM_PINS-1:0]   dout_q;
  logic [NUM_PINS-1:0]   mask_q;
  logic [NUM_PINS-1:0]   indis_q;
  logic [NUM_PINS-1:0]   sync_q;
  logic [NUM_PINS-1:0]   pin_state;

  gpio_reg_bank #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .sel       (bus_sel),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .pin_state (pin_state),
    .mode_q    (mode_q),
    .dout_q    (dout_q),
    .mask_q    (mask_q),
    .indis_q   (indis_q),
    .rdata     (bus_rdata)
  );

  gpio_in_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_q)
  );

  // Input disable forces the sampled level to 0
  assign pin_state = sync_q & ~indis_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_drive u_drive (
      .clk   (clk),
      .rst   (rst),
      .mode  (pin_mode_e'(mode_q[2*i +: 2])),
      .dbit  (dout_q[i]),
      .out_q (pad_out[i]),
      .oe_q  (pad_oe[i]),
      .pu_q  (pad_pu[i])
    );
  end

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [NUM_PINS-1:0]   pad_in,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe,
  input logic [NUM_PINS-1:0]   pad_pu,
  input logic [2*NUM_PINS-1:0] mode_q,
  input logic [NUM_PINS-1:0]   dout_q,
  input logic [NUM_PINS-1:0]   mask_q,
  input logic [NUM_PINS-1:0]   indis_q,
  input logic [NUM_PINS-1:0]   sync_q
);
  import gpio_port_pkg::*;

  logic [1:0] age_q;
  logic       dout_wr, pin_wr, pin_rd;

  assign dout_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_DOUT));
  assign pin_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(REG_PIN));
  assign pin_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(REG_PIN));

  always_ff @(posedge clk) begin
    if (rst)               age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    dout_wr |=> ((dout_q ^ $past(dout_q)) & $past(mask_q)) == '0);

  assert_dout_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !dout_wr |=> $stable(dout_q));

  assert_sync_depth_R8: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd2) |-> sync_q == $past(pad_in, 2));

  assert_indis_zero_R9: assert property (@(posedge clk) disable iff (rst)
    pin_rd |=> (bus_rdata[NUM_PINS-1:0] & $past(indis_q)) == '0);

  assert_ro_pin_R10: assert property (@(posedge clk) disable iff (rst)
    pin_wr |=> $stable(mode_q) && $stable(dout_q) && $stable(mask_q) && $stable(indis_q));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
    assert_input_off_R4: assert property (@(posedge clk) disable iff (rst)
      (mode_q[2*i +: 2] == PM_INPUT) |=> !pad_oe[i] && !pad_pu[i] && !pad_out[i]);

    assert_push_R5: assert property (@(posedge clk) disable iff (rst)
      (mode_q[2*i +: 2] == PM_PUSH) |=> pad_oe[i] && (pad_out[i] == $past(dout_q[i])));

    assert_drain_R6: assert property (@(posedge clk) disable iff (rst)
      (mode_q[2*i +: 2] == PM_DRAIN) |=> !pad_out[i] && !pad_pu[i]);

    assert_quasi_R7: assert property (@(posedge clk) disable iff (rst)
      (mode_q[2*i +: 2] == PM_QUASI) |=> !pad_out[i] && (pad_oe[i] != pad_pu[i]));
  end

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_pu    (pad_pu),
  .mode_q    (mode_q),
  .dout_q    (dout_q),
  .mask_q    (mask_q),
  .indis_q   (indis_q),
  .sync_q    (sync_q)
);

// File: tb/gpio_port_regs_test.sv
`timescale 1ns/1ps
module gpio_port_regs_test;
  localparam int unsigned N  = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pad_pu;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_port_regs #(.NUM_PINS(N), .DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // Pad outputs settle one clock after the write edge (R12)
  task automatic check_pads(input string tag, input logic [N-1:0] eo, input logic [N-1:0] ee,
                            input logic [N-1:0] ep);
    @(negedge clk);
    check({tag, " out"}, DW'(pad_out), DW'(eo));
    check({tag, " oe"},  DW'(pad_oe),  DW'(ee));
    check({tag, " pu"},  DW'(pad_pu),  DW'(ep));
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 out", DW'(pad_out), '0);
    check("R1 oe",  DW'(pad_oe),  '0);
    check("R1 pu",  DW'(pad_pu),  '0);
    rd(0, v); check("R1 mode", v, 32'h0);
    rd(1, v); check("R1 dout", v, 32'h0000_FFFF);
    rd(2, v); check("R1 mask", v, 32'h0);
    rd(3, v); check("R1 indis", v, 32'h0);
  endtask

  task automatic t_masked();
    logic [DW-1:0] v;
    wr(2, 32'h0000_00FF);
    wr(1, 32'h0000_1234);
    rd(1, v); check("R2 masked write", v, 32'h0000_12FF);
    wr(2, 32'h0000_FFDF);
    wr(1, 32'h0000_0000);
    rd(1, v); check("R3 clear pin5", v, 32'h0000_12DF);
    wr(1, 32'h0000_FFFF);
    rd(1, v); check("R3 set pin5", v, 32'h0000_12FF);
    wr(2, 32'h0);
    wr(1, 32'h0000_A5A5);
    rd(1, v); check("R2 unmasked write", v, 32'h0000_A5A5);
  endtask

  task automatic t_modes();
    wr(0, 32'h5555_5555);
    check_pads("R5 R12 push", 16'hA5A5, 16'hFFFF, 16'h0000);
    wr(0, 32'hAAAA_AAAA);
    check_pads("R6 drain", 16'h0000, 16'h5A5A, 16'h0000);
    wr(0, 32'hFFFF_FFFF);
    check_pads("R7 quasi", 16'h0000, 16'h5A5A, 16'hA5A5);
    wr(0, 32'h0000_0039);
    check_pads("R4 R5 R6 R7 mixed", 16'h0001, 16'h0003, 16'h0004);
    wr(0, 32'h0);
    check_pads("R4 input", 16'h0000, 16'h0000, 16'h0000);
  endtask

  task automatic t_pin_read();
    logic [DW-1:0] v;
    @(negedge clk);
    pad_in = 16'h3C0F;
    rd(4, v); check("R8 one clock old", v, 32'h0);
    rd(4, v); check("R8 synced", v, 32'h0000_3C0F);
    pad_in = 16'hFFFF;
    repeat (5) @(negedge clk);
    check("R11 rdata hold", bus_rdata, 32'h0000_3C0F);
  endtask

  task automatic t_indis();
    logic [DW-1:0] v;
    wr(3, 32'h0000_00F0);
    rd(4, v); check("R9 disabled bits", v, 32'h0000_FF0F);
    wr(3, 32'h0);
    rd(4, v); check("R9 re-enabled", v, 32'h0000_FFFF);
  endtask

  task automatic t_readonly();
    logic [DW-1:0] v;
    wr(1, 32'h0000_5A5A);
    wr(4, 32'h0);
    rd(4, v); check("R10 pin unchanged", v, 32'h0000_FFFF);
    rd(1, v); check("R10 dout unchanged", v, 32'h0000_5A5A);
    rd(0, v); check("R10 mode unchanged", v, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_masked();
    t_modes();
    t_pin_read();
    t_indis();
    t_readonly();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule